// File: doc/BRIEF.md
# Byte-wide PROM configuration serializer

This block is the master side of a parallel configuration load. It drives an address bus into an external byte-wide PROM and takes in one data byte per read. The byte is then sent out one bit at a time on a serial output, so that further devices in a daisy chain can be configured from the overflow.

Raising the enable starts a load. The address counter loads a start value on that edge. The start value is either a user-supplied address, which lets the upper bits pick one of several stored images, or a default: zero when counting up, all ones when counting down. From then on the block takes in one byte every eight clocks, and the address advances on that same capturing edge. The serial output updates only on falling clock edges. Bit 0 of a byte appears 1.5 periods after the rising edge that captured the byte. Successive bytes follow with no gap, so a downstream device can sample on every rising edge.

Top module: `cfg_prom_serializer`

## Requirements
- R1: The address output changes only on a capture edge or on the enable edge that loads the start value. On a capture edge it advances on that same edge, and otherwise it holds.
- R2: The address steps by exactly one per captured byte and wraps modulo 2^18. It decrements when `dir_down_i` was 1 on the enable edge and increments when it was 0. Later changes of `dir_down_i` have no effect on the running load.
- R3: On the first rising edge where `en_i` is high while idle (edge S), the address loads `start_addr_i` if `use_start_i` is 1. Otherwise it loads 0 (up) or 0x3FFFF (down). Changes to these inputs after S have no effect.
- R4: Byte k (k = 0, 1, ...) is captured from address start ± k on rising edge S+1+8k, with no other captures.
- R5: `byte_stb_o` is 1 for exactly the one clock cycle that follows each capture edge and 0 otherwise.
- R6: Bits go out least significant first. Bit j of byte k is on `dout_o` from the falling edge after rising edge S+2+8k+j until the next falling edge, so bit 0 appears 1.5 periods after its capture edge and bytes follow back to back.
- R7: `dout_o` changes only on falling clock edges.
- R8: While `en_i` is low, `dout_o` is 1 and `byte_stb_o` is 0. Dropping `en_i` at a rising edge abandons any partly sent byte: `dout_o` is 1 from the next falling edge and the address holds.
- R9: After reset the address is 0, `dout_o` is 1 and `byte_stb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Level enable; a rising level starts a load |
| dir_down_i | input | 1 | Count direction at start: 1 = decrement, 0 = increment |
| use_start_i | input | 1 | 1 = load `start_addr_i`, 0 = load default start |
| start_addr_i | input | 18 | User start address |
| prom_addr_o | output | 18 | Address to the PROM |
| prom_data_i | input | 8 | Byte read from the PROM |
| dout_o | output | 1 | Serial data, updated on falling edges |
| byte_stb_o | output | 1 | One-cycle pulse per captured byte |

## Verification
The assertions assume that the PROM returns valid data for the current address within the cycle before a capture edge. They also assume that `en_i`, `dir_down_i` and the start inputs change only away from the rising edge. The bench models the PROM as a combinational function of `prom_addr_o` and drives every input half a period away from the rising edge. While a load is running, the bench toggles the direction and start inputs at random to show that only their values at the enable edge count. Runs that start near either end of the address space force the wrap.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_ser_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              dir_i,
  input  logic              use_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, init_addr;
  step_dir_e         dir_q;

  always_comb begin
    if (use_start_i) init_addr = start_addr_i;
    else             init_addr = dir_i ? '1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dir_q  <= DIR_UP;
    end else if (load_i) begin
      addr_q <= init_addr;
      dir_q  <= step_dir_e'(dir_i);
    end else if (step_i) begin
      addr_q <= (dir_q == DIR_DOWN) ? addr_q - ONE : addr_q + ONE;
    end
  end

  assign addr_o = addr_q;

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> addr_q == (($past(dir_q) == DIR_DOWN) ? $past(addr_q) - ONE
                                                                 : $past(addr_q) + ONE));

  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(addr_q));
endmodule

// File: rtl/cfg_byte_seq.sv
module cfg_byte_seq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              load_o,
  output logic              step_o,
  output logic              bit_o,
  output logic              stb_o
);
  localparam int              CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              run_q, primed_q, bit_q, stb_q;
  logic [CNT_W-1:0]  cyc_q, idx;
  logic [BYTE_W-1:0] hold_q;

  assign load_o = en_i && !run_q;
  assign step_o = en_i && run_q && (cyc_q == '0);

  // bit index lags the cycle count by one; slot 0 sends the previous byte's MSB
  assign idx = (cyc_q == '0) ? LAST : cyc_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      primed_q <= 1'b0;
      cyc_q    <= '0;
      hold_q   <= '0;
      bit_q    <= 1'b1;
      stb_q    <= 1'b0;
    end else if (!en_i) begin
      run_q    <= 1'b0;
      primed_q <= 1'b0;
      cyc_q    <= '0;
      bit_q    <= 1'b1;
      stb_q    <= 1'b0;
    end else if (!run_q) begin
      run_q    <= 1'b1;
      primed_q <= 1'b0;
      cyc_q    <= '0;
      bit_q    <= 1'b1;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= step_o;
      cyc_q <= (cyc_q == LAST) ? '0 : cyc_q + CNT_W'(1);
      if (step_o) begin
        hold_q   <= data_i;
        primed_q <= 1'b1;
      end
      if (primed_q) bit_q <= hold_q[idx];
    end
  end

  assign bit_o = bit_q;
  assign stb_o = stb_q;

  // R5
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

  // R8
  stb_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stb_q && bit_q);
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic dout_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_o <= 1'b1;
    else         dout_o <= bit_i;
  end

  // R7
  half_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_o == bit_i);
endmodule

// File: rtl/cfg_prom_serializer.sv
module cfg_prom_serializer #(
  parameter int ADDR_W = 18,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dir_down_i,
  input  logic              use_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] prom_addr_o,
  input  logic [BYTE_W-1:0] prom_data_i,
  output logic              dout_o,
  output logic              byte_stb_o
);
  logic load, step, bit_nxt;

  cfg_byte_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .data_i (prom_data_i),
    .load_o (load),
    .step_o (step),
    .bit_o  (bit_nxt),
    .stb_o  (byte_stb_o)
  );

  cfg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .step_i       (step),
    .dir_i        (dir_down_i),
    .use_start_i  (use_start_i),
    .start_addr_i (start_addr_i),
    .addr_o       (prom_addr_o)
  );

  cfg_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_nxt),
    .dout_o (dout_o)
  );

  // R1
  stb_after_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |-> !$stable(prom_addr_o));
endmodule

// File: tb/cfg_prom_serializer_tb.sv
module cfg_prom_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, dir_down = 1'b0, use_start = 1'b0;
  logic [17:0] start_addr = '0;
  logic [17:0] prom_addr;
  logic [7:0]  prom_data;
  logic        dout, stb;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] prom_byte(input logic [17:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ a[15:8] ^ {a[17:16], a[17:12]} ^ 8'h5A;
  endfunction

  assign prom_data = prom_byte(prom_addr);

  cfg_prom_serializer u_dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .dir_down_i (dir_down),
    .use_start_i (use_start), .start_addr_i (start_addr),
    .prom_addr_o (prom_addr), .prom_data_i (prom_data),
    .dout_o (dout), .byte_stb_o (stb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // caller sits just after a falling edge
  task automatic run_case(input logic dn, input logic us, input logic [17:0] sa,
                          input int n, input bit noise);
    logic [17:0] base, exp_a;
    logic [7:0]  b;
    logic        prev, exp_d;
    int          k;
    base = us ? sa : (dn ? 18'h3FFFF : 18'h0);
    exp_a = base;
    dir_down = dn; use_start = us; start_addr = sa; en = 1'b1;
    prev = dout;
    for (int t = 0; t < n; t++) begin
      @(posedge clk); #2;
      k = (t == 0) ? 0 : (t - 1) / 8 + 1;
      exp_a = dn ? base - 18'(k) : base + 18'(k);
      chk(prom_addr == exp_a, "R1/R2/R3 addr", 32'(prom_addr), 32'(exp_a));
      chk(stb == (t >= 1 && (t - 1) % 8 == 0), "R4/R5 strobe", 32'(stb), 32'(t >= 1 && (t - 1) % 8 == 0));
      if (t > 0) chk(dout == prev, "R7 dout stable at rise", 32'(dout), 32'(prev));
      if (noise) begin
        dir_down = 1'($urandom); use_start = 1'($urandom); start_addr = 18'($urandom);
      end
      @(negedge clk); #1;
      if (t < 2) exp_d = 1'b1;
      else begin
        b = prom_byte(dn ? base - 18'((t - 2) / 8) : base + 18'((t - 2) / 8));
        exp_d = b[(t - 2) % 8];
      end
      chk(dout == exp_d, "R6 serial bit", 32'(dout), 32'(exp_d));
      prev = dout;
    end
    en = 1'b0;
    @(posedge clk); #2;
    chk(stb == 1'b0, "R8 strobe idle", 32'(stb), 32'd0);
    chk(prom_addr == exp_a, "R1 addr holds on stop", 32'(prom_addr), 32'(exp_a));
    @(negedge clk); #1;
    chk(dout == 1'b1, "R8 dout idle high", 32'(dout), 32'd1);
    @(posedge clk); #2;
    chk(stb == 1'b0 && prom_addr == exp_a, "R8 idle hold", 32'(prom_addr), 32'(exp_a));
    @(negedge clk); #1;
    chk(dout == 1'b1, "R8 dout idle high", 32'(dout), 32'd1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    #23;
    // R9
    chk(prom_addr == 18'h0, "R9 reset addr", 32'(prom_addr), 32'd0);
    chk(dout == 1'b1, "R9 reset dout", 32'(dout), 32'd1);
    chk(stb == 1'b0, "R9 reset strobe", 32'(stb), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    run_case(1'b0, 1'b0, 18'h0, 40, 1'b0);      // R3 default up
    run_case(1'b1, 1'b0, 18'h0, 40, 1'b0);      // R3 default down
    run_case(1'b0, 1'b1, 18'h3FFFD, 50, 1'b0);  // R2 wrap up
    run_case(1'b1, 1'b1, 18'h00002, 50, 1'b0);  // R2 wrap down
    run_case(1'b0, 1'b1, 18'h20000, 13, 1'b0);  // R8 stop mid-byte
    run_case(1'b0, 1'b1, 18'h20000, 30, 1'b1);  // restart, noisy inputs
    for (int i = 0; i < 8; i++)
      run_case(1'($urandom), 1'($urandom), 18'($urandom), 10 + int'($urandom % 60), 1'b1);
    report();
  end
endmodule